// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

A synthesizable behavioural model of a single-clock static memory with 18-bit words. Each word has two 9-bit byte lanes, and each lane holds eight data bits and one parity bit. All synchronous controls are captured on the rising clock edge: the address, the write data, the chip selects, the two address strobes, the advance input and the write controls. An address strobe starts a burst. After that, the advance input walks the two low address bits through four beats, in wrapping-increment order or in XOR order. The mode input chooses the order.

Reads are flow-through. The word at the address set up at an edge appears at the outputs during the cycle that follows, with no extra output register. The output enable acts without the clock: `outValid` and `dout` follow it within the same cycle. A write captured at one edge is committed to the array at the next edge. A sleep input blocks all new activity and leaves the stored contents unchanged. The array has no reset, so software or the environment must write a word before reading it.

Top module: `flow_burst_sram`

## Requirements
- R1: An access starts only when `ce1N`=0, `ce2`=1 and `ce3N`=0 are all true while a strobe is active. `adscN`=0 always counts as a strobe. `adspN`=0 counts only while `ce1N`=0. A strobe seen while the part is not selected ends any burst, and `outValid` stays 0. With `ce1N`=1, `adspN`=0 and `adscN`=1, a running burst continues unaffected.
- R2: A started access uses the captured address for its first beat. A read's data appears on `dout` with `outValid`=1 during the clock cycle right after the capturing edge.
- R3: `advN`=0 with no strobe active steps a 2-bit beat count. Only address bits [1:0] change. The upper bits keep the captured value.
- R4: With `burstIlv`=0, beat n uses low bits (start + n) mod 4.
- R5: With `burstIlv`=1, beat n uses low bits start XOR n.
- R6: With no strobe and `advN`=1 during a burst, the same address is accessed again.
- R7: `bweN`=0 with `bwN[0]`=0 writes bits [8:0]. `bweN`=0 with `bwN[1]`=0 writes bits [17:9]. A lane whose enable is not active keeps its old value.
- R8: `gwN`=0 writes both lanes, whatever `bweN` and `bwN` are.
- R9: `gwN`=1 together with `bweN`=1 makes the cycle a read, and the array is left unchanged.
- R10: `outValid` is 1 only when `oeN`=0, and `dout` is 0 whenever `outValid`=0. A change on `oeN` takes effect within the same cycle.
- R11: While `snooze`=1 at an edge, no access starts, any burst ends and no write is captured. Stored words are kept.
- R12: During a write cycle, `outValid`=0. A later read of that address returns the written data.
- R13: After the fourth beat, a further advance wraps to the start value, inside the same aligned group of four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| din | input | 18 | Write data, lane B in [17:9], lane A in [8:0] |
| ce1N | input | 1 | Primary select, active low |
| ce2 | input | 1 | Second select, active high |
| ce3N | input | 1 | Third select, active low |
| adspN | input | 1 | Processor-side address strobe, active low |
| adscN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| bweN | input | 1 | Master enable for the lane writes, active low |
| bwN | input | 2 | Lane write enables, bit 0 = lane A, active low |
| gwN | input | 1 | Write both lanes, active low |
| oeN | input | 1 | Output enable, asynchronous, active low |
| snooze | input | 1 | Sleep, blocks accesses |
| burstIlv | input | 1 | 1 = XOR burst order, 0 = wrapping increment |
| dout | output | 18 | Read data, 0 when not valid |
| outValid | output | 1 | Read data is being driven |

## Verification
The bench starts bursts at non-zero offsets in both orders and then goes on past the fourth beat. A counter that carried into bit 2, or that confused the two orders, would read a word from the next group. It writes single lanes with the other lane's data deliberately different, and it raises the global write while the lane enables are inactive. A decode that mixed up the lanes or ignored the override would then leave wrong or stale bits. It holds the primary select high during a processor strobe in the middle of a burst, and it asserts sleep in the middle of a burst. A design that honoured the strobe, or kept the burst alive, would show a valid read where none is expected. Random traffic is compared against a bench reference model. This also covers reads that follow writes and toggling of the output enable within a cycle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic             access;
    logic [LANES-1:0] wrLane;
  } ctrlStrobes_t;
endpackage

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
  import fbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              gwN,
  input  logic              snooze,
  input  logic              burstIlv,
  output ctrlStrobes_t      strb,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  beatCnt;
  logic [CNT_W-1:0]  lowBits;
  logic [LANES-1:0]  laneNext;
  logic              selOk;
  logic              strobeHit;
  logic              startHit;

  assign selOk     = !ce1N && ce2 && !ce3N;
  assign strobeHit = (!adspN && !ce1N) || !adscN;
  assign startHit  = strobeHit && selOk;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneNext[g] = !gwN || (!bweN && !bwN[g]);
  end

  always_comb begin
    if (burstIlv) lowBits = baseAddr[CNT_W-1:0] ^ beatCnt;
    else          lowBits = baseAddr[CNT_W-1:0] + beatCnt;
    curAddr = {baseAddr[ADDR_W-1:CNT_W], lowBits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      strb     <= '0;
    end else if (snooze) begin
      strb <= '0;
    end else if (startHit) begin
      baseAddr    <= addr;
      beatCnt     <= '0;
      strb.access <= 1'b1;
      strb.wrLane <= laneNext;
    end else if (strobeHit) begin
      strb <= '0;
    end else if (strb.access) begin
      if (!advN) beatCnt <= beatCnt + 1'b1;
      strb.wrLane <= laneNext;
    end else begin
      strb <= '0;
    end
  end

  AST_SNOOZE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    snooze |=> !strb.access); // R11
  AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && strobeHit && !selOk) |=> !strb.access); // R1
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && startHit) |=> (curAddr == $past(addr))); // R2
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && !strobeHit && strb.access && advN) |=> ($stable(curAddr) || !$stable(burstIlv))); // R6
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && !strobeHit && strb.access) |=> (curAddr[ADDR_W-1:CNT_W] == $past(curAddr[ADDR_W-1:CNT_W]))); // R3
  AST_GLOBAL_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && (startHit || (!strobeHit && strb.access)) && !gwN) |=> (strb.wrLane == '1)); // R8
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && (startHit || (!strobeHit && strb.access)) && gwN && bweN) |=> (strb.wrLane == '0)); // R9
endmodule

// File: rtl/fbs_data.sv
module fbs_data
  import fbs_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [WORD_W-1:0] din,
  input  logic              oeN,
  output logic [WORD_W-1:0] dout,
  output logic              outValid
);
  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] dinReg;
  logic [WORD_W-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dinReg <= '0;
    else       dinReg <= din;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strb.wrLane[i])
        memArr[curAddr][i*LANE_W +: LANE_W] <= dinReg[i*LANE_W +: LANE_W];
    end
  end

  assign rdWord   = memArr[curAddr];
  assign outValid = strb.access && (strb.wrLane == '0) && !oeN;
  assign dout     = outValid ? rdWord : '0;

  AST_QUIET_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!outValid && dout == '0)); // R10
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLane != '0) |-> !outValid); // R12
endmodule

// File: rtl/flow_burst_sram.sv
module flow_burst_sram
  import fbs_pkg::*;
#(
  parameter  int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [17:0]       din,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              bweN,
  input  logic [1:0]        bwN,
  input  logic              gwN,
  input  logic              oeN,
  input  logic              snooze,
  input  logic              burstIlv,
  output logic [17:0]       dout,
  output logic              outValid
);
  ctrlStrobes_t      strb;
  logic [ADDR_W-1:0] curAddr;

  fbs_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .bweN(bweN), .bwN(bwN),
    .gwN(gwN), .snooze(snooze), .burstIlv(burstIlv), .strb(strb), .curAddr(curAddr)
  );

  fbs_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .curAddr(curAddr), .din(din),
    .oeN(oeN), .dout(dout), .outValid(outValid)
  );
endmodule

// File: tb/test_flow_burst_sram.sv
module test_flow_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 0, rstN = 0;
  logic [ADDR_W-1:0] addr;
  logic [17:0] din, dout;
  logic ce1N, ce2, ce3N, adspN, adscN, advN, bweN, gwN, oeN, snooze, burstIlv, outValid;
  logic [1:0] bwN;

  flow_burst_sram #(.DEPTH(DEPTH)) i_flow_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .din(din), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .bweN(bweN), .bwN(bwN), .gwN(gwN),
    .oeN(oeN), .snooze(snooze), .burstIlv(burstIlv), .dout(dout), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  string curReq = "R2";

  logic [17:0] mMem [DEPTH];
  logic [ADDR_W-1:0] mBase;
  logic [1:0] mCnt, mPend;
  logic mAct;
  logic [17:0] mData;

  function automatic logic [17:0] pat(int a);
    return 18'((a * 2731 + 77) & 18'h3FFFF);
  endfunction

  function automatic logic [ADDR_W-1:0] beatAddr(logic [ADDR_W-1:0] b, int n, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce1N = 0; ce2 = 1; ce3N = 0; adspN = 1; adscN = 1; advN = 1;
    bweN = 1; bwN = 2'b11; gwN = 1; snooze = 0; oeN = 0;
  endtask

  task automatic tick();
    logic strobe, sel;
    logic [1:0] lanes;
    logic expV;
    logic [17:0] expD;
    @(posedge clk);
    for (int i = 0; i < 2; i++)
      if (mPend[i]) mMem[beatAddr(mBase, mCnt, burstIlv)][i*9 +: 9] = mData[i*9 +: 9];
    strobe = (!adspN && !ce1N) || !adscN;
    sel = !ce1N && ce2 && !ce3N;
    for (int i = 0; i < 2; i++) lanes[i] = !gwN || (!bweN && !bwN[i]);
    if (snooze) begin mAct = 0; mPend = 0; end
    else if (strobe && sel) begin mBase = addr; mCnt = 0; mAct = 1; mPend = lanes; mData = din; end
    else if (strobe) begin mAct = 0; mPend = 0; end
    else if (mAct) begin if (!advN) mCnt++; mPend = lanes; mData = din; end
    else mPend = 0;
    @(negedge clk);
    expV = mAct && !oeN && (mPend == 0);
    expD = expV ? mMem[beatAddr(mBase, mCnt, burstIlv)] : 18'h0;
    check(curReq, {outValid, dout}, {expV, expD});
  endtask

  task automatic expectRead(string req, logic [17:0] exp);
    check(req, {outValid, dout}, {1'b1, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle(); addr = '0; din = '0; burstIlv = 0;
    mAct = 0; mPend = 0; mCnt = 0; mBase = '0; mData = '0;
    repeat (3) @(negedge clk);
    check("R10 reset", {outValid, dout}, 19'h0);
    rstN = 1;
    @(negedge clk);

    // fill the array with global writes
    curReq = "R8 fill";
    for (int a = 0; a < DEPTH; a++) begin
      idle(); adscN = 0; gwN = 0; addr = ADDR_W'(a); din = pat(a); tick();
    end
    idle(); tick();

    // R2: single read, data in the following cycle
    curReq = "R2";
    idle(); adspN = 0; addr = 5; tick(); expectRead("R2", pat(5));

    // R4 and R13: linear burst from low bits 2, then wrap
    curReq = "R4"; burstIlv = 0;
    idle(); adspN = 0; addr = 6; tick(); expectRead("R4", pat(6));
    idle(); advN = 0; tick(); expectRead("R4", pat(7));
    tick(); expectRead("R4", pat(4));
    tick(); expectRead("R4", pat(5));
    curReq = "R13"; tick(); expectRead("R13", pat(6));

    // R5 and R3: XOR burst from 0x19, upper bits held
    curReq = "R5"; burstIlv = 1;
    idle(); adscN = 0; addr = 6'h19; tick(); expectRead("R5", pat(25));
    idle(); advN = 0; tick(); expectRead("R5", pat(24));
    tick(); expectRead("R3", pat(27));
    tick(); expectRead("R5", pat(26));
    // R6: hold
    curReq = "R6"; idle(); tick(); expectRead("R6", pat(26));
    // R1: processor strobe ignored while ce1N high, burst continues
    curReq = "R1"; idle(); ce1N = 1; adspN = 0; advN = 0; tick(); expectRead("R1", pat(25));
    // R1: controller strobe with ce2 low deselects
    idle(); ce2 = 0; adscN = 0; addr = 3; tick();
    check("R1", {outValid, dout}, 19'h0);
    idle(); ce3N = 1; adscN = 0; addr = 3; tick();
    check("R1", {outValid, dout}, 19'h0);
    burstIlv = 0;

    // R7: lane A only, lane B only
    curReq = "R7";
    idle(); adscN = 0; bweN = 0; bwN = 2'b10; addr = 3; din = 18'h3FFFF; tick();
    check("R12", {outValid, dout}, 19'h0);
    idle(); adscN = 0; addr = 3; tick(); expectRead("R7", {pat(3)[17:9], 9'h1FF});
    idle(); adscN = 0; bweN = 0; bwN = 2'b01; addr = 4; din = 18'h0; tick();
    idle(); adscN = 0; addr = 4; tick(); expectRead("R7", {9'h0, pat(4)[8:0]});

    // R8: global write overrides inactive lane enables
    curReq = "R8";
    idle(); adscN = 0; gwN = 0; addr = 8; din = 18'h2A5A5; tick();
    idle(); adscN = 0; addr = 8; tick(); expectRead("R8", 18'h2A5A5);

    // R9: no write when both write controls high
    curReq = "R9";
    idle(); adscN = 0; bwN = 2'b00; addr = 9; din = 18'h11111; tick();
    idle(); adscN = 0; addr = 9; tick(); expectRead("R9", pat(9));

    // R10: output enable acts within the cycle
    curReq = "R10";
    idle(); oeN = 1; adscN = 0; addr = 10; tick();
    check("R10", {outValid, dout}, 19'h0);
    oeN = 0; #1;
    expectRead("R10", pat(10));

    // R11: snooze ends burst, blocks write, keeps contents
    curReq = "R11";
    idle(); adscN = 0; addr = 12; tick();
    idle(); snooze = 1; adscN = 0; gwN = 0; addr = 12; din = 18'h0; tick();
    check("R11", {outValid, dout}, 19'h0);
    idle(); snooze = 1; advN = 0; tick();
    check("R11", {outValid, dout}, 19'h0);
    idle(); adscN = 0; addr = 12; tick(); expectRead("R11", pat(12));

    // R12: random traffic against the reference model
    curReq = "R12 random";
    for (int n = 0; n < 1500; n++) begin
      idle();
      addr = ADDR_W'($urandom);
      din = 18'($urandom);
      adspN = ($urandom % 4) != 0;
      adscN = ($urandom % 4) != 0;
      advN = $urandom % 2;
      ce1N = ($urandom % 6) == 0;
      ce2 = ($urandom % 8) != 0;
      ce3N = ($urandom % 8) == 0;
      gwN = ($urandom % 4) != 0;
      bweN = $urandom % 2;
      bwN = 2'($urandom);
      oeN = ($urandom % 5) == 0;
      snooze = ($urandom % 20) == 0;
      burstIlv = $urandom % 2;
      tick();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule